// File: doc/BRIEF.md
# Call Progress Cadence Classifier

This block names a supervisory telephone tone from its on/off rhythm. Upstream logic supplies a synchronous tone-present flag that is already qualified, and a periodic timing tick. The classifier counts ticks while the tone is present and while it is absent. It checks each completed on/off pair against tolerance windows and reports a class code with a one-cycle valid strobe. The classes are dial (continuous tone), busy, reorder, ringing and unknown.

A registered copy of the tone flag is also provided as a raw cadence bit. That bit shares one output pin with a serial digit-data bit, and a select input chooses which of the two drives the pin. The tick rate (ticks per second), the tolerance in percent and the continuous-tone threshold are parameters. A host that needs only the class codes can ignore the pin. A host that shares the line with a digit decoder steers the pin with the select input.

Top module: `cadence_classifier`

## Requirements
- R1: A synchronous reset (`rst_i` high at a clock edge) clears both tick counters and all state, and drives `class_o` to 0, `class_valid_o` to 0 and `cadence_o` to 0, whatever the tone input is.
- R2: `cadence_o` equals `tone_i` delayed by exactly one clock. `pin_o` equals `cadence_o` when `cp_sel_i` is 1 and equals `digit_sd_i` when `cp_sel_i` is 0.
- R3: Intervals are measured in ticks. Nominal ticks = ms*TICK_HZ/1000. An interval matches when lo <= ticks <= hi, where lo = nominal*(100-TOL_PCT)/100 and hi = nominal*(100+TOL_PCT)/100, using integer division.
- R4: An on/off pair with both intervals inside the 250 ms windows is the reorder class, code 3.
- R5: An on/off pair with both intervals inside the 500 ms windows is the busy class, code 2.
- R6: An on/off pair with the on interval inside the 2000 ms window and the off interval inside the 4000 ms window is the ringing class, code 4.
- R7: When tone is present without a break for CONT_MS worth of ticks, the dial class (code 1) is reported once, on the tick that reaches the threshold. The on interval that ends after such a report is not evaluated as a pair. One tick less than the threshold reports no dial.
- R8: A pair is evaluated at each rising edge of tone that follows a measured on interval. A class is reported only when two consecutive pairs give the same class, with a single one-cycle strobe. Further matching pairs do not strobe again. A pair of a different class restarts the count.
- R9: A pair that matches no window reports code 0 (unknown) with a strobe, and restarts the match count.
- R10: The tick counters saturate at their maximum value rather than wrap, so a very long interval never aliases into a valid window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Timing tick, one cycle wide, TICK_HZ per second |
| tone_i | input | 1 | Qualified tone-present flag |
| digit_sd_i | input | 1 | Serial digit data bit sharing the output pin |
| cp_sel_i | input | 1 | 1: pin carries cadence, 0: pin carries digit data |
| class_o | output | 3 | Class code: 0 unknown, 1 dial, 2 busy, 3 reorder, 4 ringing |
| class_valid_o | output | 1 | One-cycle strobe when `class_o` is updated |
| cadence_o | output | 1 | Registered tone presence |
| pin_o | output | 1 | Shared output pin |

## Verification
The assertions check on every cycle that the strobe is never longer than one cycle, that codes stay within the legal set, and that the cadence bit tracks the tone input by one clock. They also check that each strobe is caused by a tick or by a tone rising edge, and that a dial report only happens while the tone is present. Only the bench's scenarios can show the timing itself. A near-exhaustive sweep puts each pattern's on and off lengths at and just beyond both window edges. Further scenarios cover the two-cycle confirmation, the break when the class changes, the continuous-tone threshold, and saturation on intervals far longer than any window.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

    typedef enum logic [2:0] {
        CLS_UNKNOWN = 3'd0,
        CLS_DIAL    = 3'd1,
        CLS_BUSY    = 3'd2,
        CLS_REORDER = 3'd3,
        CLS_RINGING = 3'd4
    } cls_e;

    // nominal interval length in ticks
    function automatic int ticks_of(input int ms, input int hz);
        return (ms * hz) / 1000;
    endfunction

    function automatic int win_lo(input int nom, input int tol);
        return (nom * (100 - tol)) / 100;
    endfunction

    function automatic int win_hi(input int nom, input int tol);
        return (nom * (100 + tol)) / 100;
    endfunction

    // counter width covering the longest window and the continuous threshold
    function automatic int cnt_width(input int hz, input int tol, input int cont_ms);
        int longest;
        int cont;
        longest = win_hi(ticks_of(4000, hz), tol);
        cont    = ticks_of(cont_ms, hz);
        if (cont > longest) longest = cont;
        return $clog2(longest + 2);
    endfunction

endpackage

// File: rtl/ccc_sat_counter.sv
module ccc_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (inc_i && (cnt_q != TOP)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= '0;
        else       cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/ccc_window_match.sv
module ccc_window_match
    import ccc_pkg::*;
#(
    parameter int TICK_HZ = 1000,
    parameter int TOL_PCT = 20,
    parameter int CNT_W   = 13
) (
    input  logic [CNT_W-1:0] on_len_i,
    input  logic [CNT_W-1:0] off_len_i,
    output cls_e             cls_o
);
    localparam int NPAT = 3;
    localparam int ON_MS  [NPAT] = '{250, 500, 2000};
    localparam int OFF_MS [NPAT] = '{250, 500, 4000};
    localparam cls_e PAT_CLS [NPAT] = '{CLS_REORDER, CLS_BUSY, CLS_RINGING};

    logic [NPAT-1:0] hit;

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        localparam int ON_NOM  = ticks_of(ON_MS[g], TICK_HZ);
        localparam int OFF_NOM = ticks_of(OFF_MS[g], TICK_HZ);
        localparam int ON_LO   = win_lo(ON_NOM, TOL_PCT);
        localparam int ON_HI   = win_hi(ON_NOM, TOL_PCT);
        localparam int OFF_LO  = win_lo(OFF_NOM, TOL_PCT);
        localparam int OFF_HI  = win_hi(OFF_NOM, TOL_PCT);
        logic on_ok, off_ok;
        assign on_ok  = (int'(on_len_i)  >= ON_LO)  && (int'(on_len_i)  <= ON_HI);
        assign off_ok = (int'(off_len_i) >= OFF_LO) && (int'(off_len_i) <= OFF_HI);
        assign hit[g] = on_ok && off_ok;
    end

    always_comb begin
        cls_o = CLS_UNKNOWN;
        for (int i = NPAT - 1; i >= 0; i--) begin
            if (hit[i]) cls_o = PAT_CLS[i];
        end
    end
endmodule

// File: rtl/cadence_classifier.sv
module cadence_classifier
    import ccc_pkg::*;
#(
    parameter int TICK_HZ = 1000,
    parameter int TOL_PCT = 20,
    parameter int CONT_MS = 3000
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       tick_i,
    input  logic       tone_i,
    input  logic       digit_sd_i,
    input  logic       cp_sel_i,
    output logic [2:0] class_o,
    output logic       class_valid_o,
    output logic       cadence_o,
    output logic       pin_o
);
    localparam int CNT_W      = cnt_width(TICK_HZ, TOL_PCT, CONT_MS);
    localparam int CONT_TICKS = ticks_of(CONT_MS, TICK_HZ);

    typedef struct packed {
        logic       cad;        // tone level seen last cycle
        logic       have_on;    // an on interval has been measured
        logic       dial_done;  // dial already reported for this on interval
        logic [1:0] streak;     // consecutive matching pairs (saturates at 2)
        cls_e       last;       // class of the previous pair
        cls_e       cls;        // reported code
        logic       vld;        // strobe
    } state_t;

    state_t d, q;

    logic             rise, fall;
    logic [CNT_W-1:0] on_cnt, off_cnt;
    cls_e             pair_cls;
    logic             dial_hit;

    assign rise = tone_i & ~q.cad;
    assign fall = ~tone_i & q.cad;

    ccc_sat_counter #(.W(CNT_W)) u_on_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (rise),
        .inc_i (tone_i & tick_i),
        .cnt_o (on_cnt)
    );

    ccc_sat_counter #(.W(CNT_W)) u_off_cnt (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .clr_i (fall),
        .inc_i (~tone_i & tick_i),
        .cnt_o (off_cnt)
    );

    ccc_window_match #(.TICK_HZ(TICK_HZ), .TOL_PCT(TOL_PCT), .CNT_W(CNT_W)) u_match (
        .on_len_i  (on_cnt),
        .off_len_i (off_cnt),
        .cls_o     (pair_cls)
    );

    assign dial_hit = tone_i && q.cad && tick_i && !q.dial_done
                      && (int'(on_cnt) >= CONT_TICKS - 1);

    always_comb begin
        d     = q;
        d.cad = tone_i;
        d.vld = 1'b0;

        if (fall) begin
            d.have_on   = !q.dial_done;
            d.dial_done = 1'b0;
        end

        if (rise) begin
            d.have_on = 1'b0;
            if (q.have_on) begin
                if (pair_cls == CLS_UNKNOWN) begin
                    d.vld    = 1'b1;
                    d.cls    = CLS_UNKNOWN;
                    d.streak = 2'd0;
                    d.last   = CLS_UNKNOWN;
                end else if ((q.streak != 2'd0) && (q.last == pair_cls)) begin
                    if (q.streak == 2'd1) begin
                        d.vld = 1'b1;
                        d.cls = pair_cls;
                    end
                    d.streak = 2'd2;
                end else begin
                    d.streak = 2'd1;
                    d.last   = pair_cls;
                end
            end
        end

        if (dial_hit) begin
            d.vld       = 1'b1;
            d.cls       = CLS_DIAL;
            d.dial_done = 1'b1;
            d.streak    = 2'd0;
            d.last      = CLS_UNKNOWN;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q <= '{cad: 1'b0, have_on: 1'b0, dial_done: 1'b0, streak: 2'd0,
                   last: CLS_UNKNOWN, cls: CLS_UNKNOWN, vld: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign class_o       = q.cls;
    assign class_valid_o = q.vld;
    assign cadence_o     = q.cad;
    assign pin_o         = cp_sel_i ? q.cad : digit_sd_i;
endmodule

// File: rtl/ccc_checker.sv
module ccc_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       tick_i,
    input logic       tone_i,
    input logic [2:0] class_o,
    input logic       class_valid_o,
    input logic       cadence_o
);
    AST_RESET_QUIET: assert property (@(posedge clk_i)
        rst_i |=> (!class_valid_o && class_o == 3'd0 && !cadence_o)); // R1

    AST_CADENCE_TRACKS: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> (cadence_o == $past(tone_i))); // R2

    AST_EVENT_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        class_valid_o |-> ($past(tick_i) || $past(tone_i && !cadence_o))); // R3

    AST_DIAL_ON_TONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (class_valid_o && class_o == 3'd1) |-> ($past(tone_i) && cadence_o)); // R7

    AST_SINGLE_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
        class_valid_o |=> !class_valid_o); // R8

    AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        class_valid_o |-> (class_o <= 3'd4)); // R9
endmodule

bind cadence_classifier ccc_checker u_chk (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .tick_i        (tick_i),
    .tone_i        (tone_i),
    .class_o       (class_o),
    .class_valid_o (class_valid_o),
    .cadence_o     (cadence_o)
);

// File: tb/cadence_classifier_test.sv
module cadence_classifier_test;
    localparam int HZ  = 20;
    localparam int TOL = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0;
    logic tone = 1'b0;
    logic sd = 1'b0;
    logic sel = 1'b1;
    logic [2:0] cls;
    logic vld, cad, pin;

    int checks = 0;
    int errors = 0;
    int ev_cnt = 0;
    int ev_base = 0;
    logic [2:0] ev_last = 3'd0;

    always #5 clk = ~clk;

    cadence_classifier #(.TICK_HZ(HZ), .TOL_PCT(TOL), .CONT_MS(3000)) uut (
        .clk_i(clk), .rst_i(rst), .tick_i(tick), .tone_i(tone),
        .digit_sd_i(sd), .cp_sel_i(sel),
        .class_o(cls), .class_valid_o(vld), .cadence_o(cad), .pin_o(pin)
    );

    always @(negedge clk) begin
        if (vld) begin
            ev_cnt  <= ev_cnt + 1;
            ev_last <= cls;
        end
    end

    function automatic int nom(input int ms);
        return ms * HZ / 1000;
    endfunction
    function automatic int lo(input int ms);
        return nom(ms) * (100 - TOL) / 100;
    endfunction
    function automatic int hi(input int ms);
        return nom(ms) * (100 + TOL) / 100;
    endfunction
    function automatic int exp_class(input int on_t, input int off_t);
        if (on_t >= lo(250) && on_t <= hi(250) && off_t >= lo(250) && off_t <= hi(250)) return 3;
        if (on_t >= lo(500) && on_t <= hi(500) && off_t >= lo(500) && off_t <= hi(500)) return 2;
        if (on_t >= lo(2000) && on_t <= hi(2000) && off_t >= lo(4000) && off_t <= hi(4000)) return 4;
        return 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic seg(input logic lvl, input int n);
        @(negedge clk);
        tone = lvl;
        tick = 1'b0;
        for (int i = 0; i < n; i++) begin
            repeat (3) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic do_reset(input logic tone_lvl);
        @(negedge clk);
        rst = 1'b1; tone = tone_lvl; tick = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ev_base = ev_cnt;
    endtask

    task automatic settle;
        repeat (4) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int vals [5];
        int on_set [5];
        int off_set [5];
        int ms_on [3];
        int ms_off [3];
        int e;
        ms_on  = '{250, 500, 2000};
        ms_off = '{250, 500, 4000};

        // R1: reset state with tone held high
        rst = 1'b1; tone = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 class", cls, 0);
        check("R1 valid", vld, 0);
        check("R1 cadence", cad, 0);
        do_reset(1'b0);

        // R2: cadence follows tone by one clock, pin mux
        @(negedge clk); tone = 1'b1;
        @(negedge clk); check("R2 cadence high", cad, 1);
        sel = 1'b1; #1 check("R2 pin cadence", pin, 1);
        sel = 1'b0; sd = 1'b0; #1 check("R2 pin digit 0", pin, 0);
        sd = 1'b1; #1 check("R2 pin digit 1", pin, 1);
        sel = 1'b1;
        @(negedge clk); tone = 1'b0;
        @(negedge clk); check("R2 cadence low", cad, 0);
        #1 check("R2 pin cadence low", pin, 0);

        // R3..R6, R9: sweep of each pattern at and beyond window edges
        for (int k = 0; k < 3; k++) begin
            on_set  = '{lo(ms_on[k]) - 1, lo(ms_on[k]), nom(ms_on[k]), hi(ms_on[k]), hi(ms_on[k]) + 1};
            off_set = '{lo(ms_off[k]) - 1, lo(ms_off[k]), nom(ms_off[k]), hi(ms_off[k]), hi(ms_off[k]) + 1};
            for (int a = 0; a < 5; a++) begin
                for (int b = 0; b < 5; b++) begin
                    do_reset(1'b0);
                    for (int c = 0; c < 3; c++) begin
                        seg(1'b1, on_set[a]);
                        seg(1'b0, off_set[b]);
                    end
                    seg(1'b1, 1);
                    seg(1'b0, 1);
                    settle();
                    e = exp_class(on_set[a], off_set[b]);
                    if (e == 0) begin
                        check("R9 unknown count", ev_cnt - ev_base, 3);
                        check("R9 unknown code", ev_last, 0);
                    end else begin
                        check(k == 0 ? "R4 reorder count" : (k == 1 ? "R5 busy count" : "R6 ringing count"),
                              ev_cnt - ev_base, 1);
                        check(k == 0 ? "R4 reorder code" : (k == 1 ? "R5 busy code" : "R6 ringing code"),
                              ev_last, e);
                    end
                end
            end
        end

        // R8: long busy run strobes once
        do_reset(1'b0);
        for (int c = 0; c < 5; c++) begin
            seg(1'b1, nom(500));
            seg(1'b0, nom(500));
        end
        seg(1'b1, 1); seg(1'b0, 1); settle();
        check("R8 single strobe count", ev_cnt - ev_base, 1);
        check("R8 single strobe code", ev_last, 2);

        // R8: class change restarts confirmation
        do_reset(1'b0);
        seg(1'b1, nom(500)); seg(1'b0, nom(500));
        seg(1'b1, nom(250)); seg(1'b0, nom(250));
        seg(1'b1, nom(250)); seg(1'b0, nom(250));
        seg(1'b1, 1); settle();
        check("R8 break count", ev_cnt - ev_base, 1);
        check("R8 break code", ev_last, 3);

        // R8: one matching pair alone reports nothing
        do_reset(1'b0);
        seg(1'b1, nom(500)); seg(1'b0, nom(500)); seg(1'b1, 1); settle();
        check("R8 one pair silent", ev_cnt - ev_base, 0);

        // R7: continuous tone at the threshold
        do_reset(1'b0);
        seg(1'b1, nom(3000) + 10);
        check("R7 dial count", ev_cnt - ev_base, 1);
        check("R7 dial code", ev_last, 1);
        seg(1'b0, nom(500)); seg(1'b1, 3); seg(1'b0, 1); settle();
        check("R7 no pair after dial", ev_cnt - ev_base, 1);

        do_reset(1'b0);
        seg(1'b1, nom(3000)); settle();
        check("R7 dial exact threshold", ev_cnt - ev_base, 1);
        check("R7 dial exact code", ev_last, 1);

        do_reset(1'b0);
        seg(1'b1, nom(3000) - 1); seg(1'b0, nom(500)); seg(1'b1, 1); settle();
        check("R7 below threshold count", ev_cnt - ev_base, 1);
        check("R7 below threshold code", ev_last, 0);

        // R10: off interval far past the counter range must not alias into ringing
        do_reset(1'b0);
        for (int c = 0; c < 2; c++) begin
            seg(1'b1, nom(2000));
            seg(1'b0, 200);
        end
        seg(1'b1, 1); seg(1'b0, 1); settle();
        check("R10 saturate count", ev_cnt - ev_base, 2);
        check("R10 saturate code", ev_last, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule